// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block is the digital sequencer for a multi-rail regulator. It brings the rails up, recovers them after overloads, and shuts them down for good after a hard fault. The soft-start ramp is held in a counter. Once all three supply-ready flags are high, the counter jumps to a start level and then climbs one step at a time to full scale. The regulator enable follows the sequencer state.

A core over-current trip, or a linear-rail under-voltage after the ramp is complete, forces a restart cycle. The enable drops, the event is counted, and the ramp bleeds down to a low threshold before it charges again. The third counted event latches the fault. An over-voltage event latches the fault at once. Only the power-on reset clears the counter and the latch.

A shutdown request or an inhibit code forces the ramp to zero and turns the regulators off. It does not touch the count.

Top module: `softstart_fault_seq`

## Requirements
- R1: After reset, `ramp_o` is 0, `reg_en_o`, `ramp_done_o` and `fault_o` are low, and `oc_cnt_o` is 0. The ramp stays at 0 until all three bits of `sup_rdy_i` are 1 while `shdn_i` and `inhib_i` are low.
- R2: One cycle after starting, `ramp_o` equals START_LVL. It then rises by 1 every CHG_DIV cycles until it reaches RAMP_MAX. `reg_en_o` is high while charging. `ramp_done_o` is high once full scale is held.
- R3: A one-cycle `ov_i` pulse sets `fault_o` on the next cycle and leaves `oc_cnt_o` unchanged.
- R4: An `oc_i` pulse while the ramp is done has three effects on the next cycle: `reg_en_o` and `ramp_done_o` go low, and `oc_cnt_o` rises by 1. The ramp then falls by 1 every DIS_DIV cycles to exactly LOW_THR, reloads START_LVL and charges again.
- R5: An `oc_i` pulse while charging drops `reg_en_o` on the next cycle. The ramp keeps rising to RAMP_MAX. The count is incremented only when full scale is reached, and discharge follows.
- R6: `luv_i` has no effect while `ramp_done_o` is low. While `ramp_done_o` is high, it acts like an `oc_i` event.
- R7: When the count reaches 3, `fault_o` is set. One cycle after `fault_o` rises, `ramp_o` is 0 and `reg_en_o` is low.
- R8: The count saturates at 3. Once `fault_o` is set, further `oc_i`, `luv_i` and `ov_i` events and shutdown cycles change nothing. Only `rst_ni` clears the count and the fault.
- R9: `shdn_i` high, `inhib_i` high, or any `sup_rdy_i` bit low forces `ramp_o` to 0 and `reg_en_o` low on the next cycle. `oc_cnt_o` keeps its value. On release the ramp restarts at START_LVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset; power-on reset of the bias supply |
| sup_rdy_i | input | N_SUP | Per-supply ready flags |
| oc_i | input | 1 | Core over-current event |
| ov_i | input | 1 | Core over-voltage event |
| luv_i | input | 1 | Linear-rail under-voltage flag |
| shdn_i | input | 1 | External shutdown request |
| inhib_i | input | 1 | Inhibit code applied |
| ramp_o | output | RAMP_W | Soft-start ramp value |
| reg_en_o | output | 1 | Regulators enabled |
| ramp_done_o | output | 1 | Ramp complete, full scale held |
| fault_o | output | 1 | Fault latched |
| oc_cnt_o | output | CNT_W | Counted over-current events |

## Verification
The hardest state to reach is the third count being recorded by an over-current trip that hits mid-charge. That trip must not count until the ramp has finished climbing, while the enable is already low. The stimulus table gets there by stepping through the earlier cycles one at a time. It uses a run-time trip, then an under-voltage trip. It then holds under-voltage through the next charge to show the blanking. Finally it pulses over-current partway up that charge, so the count moves from 2 to 3 only at full scale.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHARGE, ST_RUN, ST_DISCH, ST_FAULT
  } sfs_state_e;

  typedef enum logic [2:0] {
    RC_HOLD, RC_ZERO, RC_LOAD, RC_UP, RC_DOWN
  } ramp_cmd_e;
endpackage

// File: rtl/sfs_ramp.sv
module sfs_ramp
  import sfs_pkg::*;
#(
  parameter int RAMP_MAX  = 64,
  parameter int START_LVL = 16,
  parameter int LOW_THR   = 4,
  parameter int CHG_DIV   = 2,
  parameter int DIS_DIV   = 1,
  parameter int RAMP_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ramp_cmd_e         cmd_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              at_max_o,
  output logic              at_low_o
);
  localparam int DIV_MAX = (CHG_DIV > DIS_DIV) ? CHG_DIV : DIS_DIV;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam logic [RAMP_W-1:0] MAX_V   = RAMP_W'(RAMP_MAX);
  localparam logic [RAMP_W-1:0] START_V = RAMP_W'(START_LVL);
  localparam logic [RAMP_W-1:0] LOW_V   = RAMP_W'(LOW_THR);
  localparam logic [DIV_W-1:0]  CHG_END = DIV_W'(CHG_DIV - 1);
  localparam logic [DIV_W-1:0]  DIS_END = DIV_W'(DIS_DIV - 1);

  logic [RAMP_W-1:0] ramp_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      div_q  <= '0;
    end else begin
      unique case (cmd_i)
        RC_ZERO: begin
          ramp_q <= '0;
          div_q  <= '0;
        end
        RC_LOAD: begin
          ramp_q <= START_V;
          div_q  <= '0;
        end
        RC_UP: begin
          if (ramp_q < MAX_V) begin
            if (div_q == CHG_END) begin
              ramp_q <= ramp_q + RAMP_W'(1);
              div_q  <= '0;
            end else begin
              div_q <= div_q + DIV_W'(1);
            end
          end
        end
        RC_DOWN: begin
          if (ramp_q > LOW_V) begin
            if (div_q == DIS_END) begin
              ramp_q <= ramp_q - RAMP_W'(1);
              div_q  <= '0;
            end else begin
              div_q <= div_q + DIV_W'(1);
            end
          end
        end
        default: div_q <= '0;
      endcase
    end
  end

  assign ramp_o   = ramp_q;
  assign at_max_o = (ramp_q == MAX_V);
  assign at_low_o = (ramp_q <= LOW_V);

  AST_RAMP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_q <= MAX_V); // R2
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == RC_UP) |=> (ramp_q == $past(ramp_q) || ramp_q == $past(ramp_q) + RAMP_W'(1))); // R2
  AST_DOWN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == RC_DOWN && ramp_q >= LOW_V) |=> ramp_q >= LOW_V); // R4
endmodule

// File: rtl/sfs_fault_ctr.sv
module sfs_fault_ctr #(
  parameter int OC_LIMIT = 3,
  parameter int CNT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ov_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(OC_LIMIT);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(OC_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!fault_q) begin
      if (ov_i) fault_q <= 1'b1;
      if (inc_i && cnt_q < LIM_V) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST_V) fault_q <= 1'b1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = fault_q;

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |=> fault_q); // R8
  AST_OV_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_i |=> fault_q); // R3
  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q >= $past(cnt_q)); // R8
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_V); // R8
  AST_LIMIT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIM_V) |-> fault_q); // R7
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  logic      oc_i,
  input  logic      luv_i,
  input  logic      fault_i,
  input  logic      at_max_i,
  input  logic      at_low_i,
  output ramp_cmd_e cmd_o,
  output logic      inc_o,
  output logic      reg_en_o,
  output logic      done_o
);
  sfs_state_e st_q, st_d;
  logic       pend_q, pend_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    cmd_o  = RC_HOLD;
    inc_o  = 1'b0;
    if (fault_i) begin
      st_d   = ST_FAULT;
      cmd_o  = RC_ZERO;
      pend_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cmd_o  = RC_ZERO;
          pend_d = 1'b0;
          if (go_i) begin
            st_d  = ST_CHARGE;
            cmd_o = RC_LOAD;
          end
        end
        ST_CHARGE: begin
          if (!go_i) begin
            st_d   = ST_IDLE;
            cmd_o  = RC_ZERO;
            pend_d = 1'b0;
          end else if (at_max_i) begin
            pend_d = 1'b0;
            if (pend_q || oc_i) begin
              st_d  = ST_DISCH;
              inc_o = 1'b1;
            end else begin
              st_d = ST_RUN;
            end
          end else begin
            cmd_o = RC_UP;
            if (oc_i) pend_d = 1'b1;  // count deferred until full scale
          end
        end
        ST_RUN: begin
          if (!go_i) begin
            st_d  = ST_IDLE;
            cmd_o = RC_ZERO;
          end else if (oc_i || luv_i) begin
            st_d  = ST_DISCH;
            inc_o = 1'b1;
          end
        end
        ST_DISCH: begin
          if (!go_i) begin
            st_d  = ST_IDLE;
            cmd_o = RC_ZERO;
          end else if (at_low_i) begin
            st_d  = ST_CHARGE;
            cmd_o = RC_LOAD;
          end else begin
            cmd_o = RC_DOWN;
          end
        end
        ST_FAULT: cmd_o = RC_ZERO;
        default: begin
          st_d  = ST_IDLE;
          cmd_o = RC_ZERO;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign reg_en_o = (st_q == ST_RUN) || (st_q == ST_CHARGE && !pend_q);
  assign done_o   = (st_q == ST_RUN);

  AST_LUV_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHARGE && !pend_q && !oc_i) |-> !inc_o); // R6
  AST_PEND_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHARGE && oc_i && go_i) |=> !reg_en_o); // R5
  AST_RUN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> at_max_i); // R2
endmodule

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq
  import sfs_pkg::*;
#(
  parameter int N_SUP     = 3,
  parameter int RAMP_MAX  = 64,
  parameter int START_LVL = 16,
  parameter int LOW_THR   = 4,
  parameter int CHG_DIV   = 2,
  parameter int DIS_DIV   = 1,
  parameter int OC_LIMIT  = 3,
  localparam int RAMP_W   = $clog2(RAMP_MAX + 1),
  localparam int CNT_W    = $clog2(OC_LIMIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SUP-1:0]  sup_rdy_i,
  input  logic              oc_i,
  input  logic              ov_i,
  input  logic              luv_i,
  input  logic              shdn_i,
  input  logic              inhib_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              reg_en_o,
  output logic              ramp_done_o,
  output logic              fault_o,
  output logic [CNT_W-1:0]  oc_cnt_o
);
  logic      go, inc, at_max, at_low;
  ramp_cmd_e cmd;

  assign go = (&sup_rdy_i) && !shdn_i && !inhib_i;

  sfs_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .oc_i     (oc_i),
    .luv_i    (luv_i),
    .fault_i  (fault_o),
    .at_max_i (at_max),
    .at_low_i (at_low),
    .cmd_o    (cmd),
    .inc_o    (inc),
    .reg_en_o (reg_en_o),
    .done_o   (ramp_done_o)
  );

  sfs_ramp #(
    .RAMP_MAX (RAMP_MAX),
    .START_LVL(START_LVL),
    .LOW_THR  (LOW_THR),
    .CHG_DIV  (CHG_DIV),
    .DIS_DIV  (DIS_DIV),
    .RAMP_W   (RAMP_W)
  ) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .ramp_o   (ramp_o),
    .at_max_o (at_max),
    .at_low_o (at_low)
  );

  sfs_fault_ctr #(
    .OC_LIMIT (OC_LIMIT),
    .CNT_W    (CNT_W)
  ) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .ov_i    (ov_i),
    .cnt_o   (oc_cnt_o),
    .fault_o (fault_o)
  );

  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (ramp_o == '0 && !reg_en_o)); // R7
  AST_STOP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go |=> (ramp_o == '0 && !reg_en_o)); // R9
endmodule

// File: tb/softstart_fault_seq_tb_top.sv
module softstart_fault_seq_tb_top;
  localparam int START = 16;
  localparam int FULL  = 64;
  localparam int LOW   = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sup_rdy_i = '0;
  logic       oc_i = 0, ov_i = 0, luv_i = 0, shdn_i = 0, inhib_i = 0;
  logic [6:0] ramp_o;
  logic       reg_en_o, ramp_done_o, fault_o;
  logic [1:0] oc_cnt_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  softstart_fault_seq dut_i (
    .clk_i, .rst_ni, .sup_rdy_i, .oc_i, .ov_i, .luv_i, .shdn_i, .inhib_i,
    .ramp_o, .reg_en_o, .ramp_done_o, .fault_o, .oc_cnt_o
  );

  typedef struct packed {
    logic [2:0] rdy;
    logic       shdn;
    logic       inh;
    logic       oc;
    logic       ov;
    logic       luv;
    logic [9:0] cyc;
    logic       en;
    logic       done;
    logic       flt;
    logic [1:0] cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd20,  1'b0, 1'b0, 1'b0, 2'd0}, // R1
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd10,  1'b1, 1'b0, 1'b0, 2'd0}, // R2
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd200, 1'b1, 1'b1, 1'b0, 2'd0}, // R2
    '{3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd3,   1'b0, 1'b0, 1'b0, 2'd1}, // R4
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd200, 1'b1, 1'b1, 1'b0, 2'd1}, // R4
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd3,   1'b0, 1'b0, 1'b0, 2'd2}, // R6
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd100, 1'b1, 1'b0, 1'b0, 2'd2}, // R6
    '{3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 1'b0, 2'd2}, // R5
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd200, 1'b0, 1'b0, 1'b1, 2'd3}, // R7
    '{3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 1'b1, 2'd3}, // R8
    '{3'b111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'd5,   1'b0, 1'b0, 1'b1, 2'd3}, // R8
    '{3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd200, 1'b0, 1'b0, 1'b1, 2'd3}  // R8
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    int min_r;
    do_reset();
    chk("R1 reset ramp", ramp_o, 0);
    chk("R1 reset en", reg_en_o, 0);
    chk("R1 reset fault", fault_o, 0);
    chk("R1 reset cnt", oc_cnt_o, 0);

    for (int i = 0; i < NV; i++) begin
      sup_rdy_i = VECS[i].rdy;
      shdn_i    = VECS[i].shdn;
      inhib_i   = VECS[i].inh;
      luv_i     = VECS[i].luv;
      oc_i      = VECS[i].oc;
      ov_i      = VECS[i].ov;
      @(negedge clk_i);
      oc_i = 1'b0;
      ov_i = 1'b0;
      repeat (int'(VECS[i].cyc) - 1) @(negedge clk_i);
      chk($sformatf("vec%0d en", i), reg_en_o, VECS[i].en);
      chk($sformatf("vec%0d done", i), ramp_done_o, VECS[i].done);
      chk($sformatf("vec%0d fault", i), fault_o, VECS[i].flt);
      chk($sformatf("vec%0d cnt", i), oc_cnt_o, VECS[i].cnt);
    end

    // R8: only reset clears count and fault
    sup_rdy_i = '0;
    do_reset();
    chk("R8 por cnt", oc_cnt_o, 0);
    chk("R8 por fault", fault_o, 0);

    // R2: start level then stepped rise
    sup_rdy_i = 3'b111;
    @(negedge clk_i);
    chk("R2 start level", ramp_o, START);
    repeat (20) @(negedge clk_i);
    chk("R2 step rate", ramp_o, START + 10);
    repeat (120) @(negedge clk_i);
    chk("R2 full scale", ramp_o, FULL);
    chk("R2 done", ramp_done_o, 1);

    // R4: discharge floor then restart
    oc_i = 1'b1;
    @(negedge clk_i);
    oc_i = 1'b0;
    min_r = FULL;
    for (int k = 0; k < 80; k++) begin
      if (int'(ramp_o) < min_r) min_r = ramp_o;
      @(negedge clk_i);
    end
    chk("R4 discharge floor", min_r, LOW);
    chk("R4 count", oc_cnt_o, 1);
    repeat (150) @(negedge clk_i);
    chk("R4 recharged", ramp_done_o, 1);

    // R9: shutdown, inhibit, ready loss
    shdn_i = 1'b1;
    @(negedge clk_i);
    chk("R9 shdn ramp", ramp_o, 0);
    chk("R9 shdn en", reg_en_o, 0);
    chk("R9 shdn keeps cnt", oc_cnt_o, 1);
    shdn_i = 1'b0;
    @(negedge clk_i);
    chk("R9 restart level", ramp_o, START);
    repeat (5) @(negedge clk_i);
    inhib_i = 1'b1;
    @(negedge clk_i);
    chk("R9 inhibit ramp", ramp_o, 0);
    inhib_i = 1'b0;
    repeat (5) @(negedge clk_i);
    sup_rdy_i = 3'b101;
    @(negedge clk_i);
    chk("R9 ready loss ramp", ramp_o, 0);
    chk("R9 ready loss en", reg_en_o, 0);
    sup_rdy_i = 3'b111;
    repeat (5) @(negedge clk_i);

    // R3: over-voltage latches without counting
    ov_i = 1'b1;
    @(negedge clk_i);
    ov_i = 1'b0;
    chk("R3 ov fault", fault_o, 1);
    chk("R3 ov cnt", oc_cnt_o, 1);
    @(negedge clk_i);
    chk("R7 fault ramp zero", ramp_o, 0);
    chk("R7 fault en", reg_en_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule